// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This block resolves jump-class instructions for a 64-bit register machine. For each valid instruction it receives the opcode byte, the signed 16-bit offset, the 32-bit immediate, the values of the destination and source registers, and the current program counter. The program counter counts 64-bit instruction slots. The block decides whether the branch is taken and produces the next program counter. It also flags call and exit operations, and it raises an illegal-instruction flag for encodings that are not allowed.

The block handles two compare classes with one operation table. One class compares full 64-bit operands. The other compares only the low 32 bits of each operand. Each class has equality, bit-test, unsigned and signed relations. Unconditional jump and exit are accepted only in the 64-bit class. Resolving the call target and handling the return value are left to the surrounding pipeline.

All results are registered. They appear one clock after the instruction is presented.

Top module: `br_eval_unit`

## Requirements
- R1: While reset is held low, and on the first edge after it, out_valid, taken, is_call, is_exit, illegal and next_pc are all zero.
- R2: The outputs for an instruction presented with in_valid high appear on the next clock edge, with out_valid high. A cycle with in_valid low produces out_valid low and all other outputs zero.
- R3: opcode[2:0] is the class: 5 selects 64-bit compares and 6 selects 32-bit compares. opcode[7:4] is the operation code. opcode[3] chooses the comparison operand: 1 selects the source register and 0 selects the immediate.
- R4: Operation 1 branches on equal, operation 5 branches on not equal, and operation 4 branches when the bitwise AND of the two operands is nonzero.
- R5: The unsigned relations are operation 2 (greater), 3 (greater or equal), 10 (less) and 11 (less or equal).
- R6: The signed relations are operation 6 (greater), 7 (greater or equal), 12 (less) and 13 (less or equal). The sign bit is bit 31 in the 32-bit class and bit 63 in the 64-bit class.
- R7: The immediate operand is sign-extended to 64 bits. In the 32-bit class only bits 31:0 of the destination value and of the chosen operand take part in the compare.
- R8: A taken branch gives next_pc = pc + 1 + sign-extended offset, modulo 2^PCW. Any other instruction gives next_pc = pc + 1.
- R9: Operation 0 in the 64-bit class is always taken.
- R10: Operation 8 asserts is_call in either class, and operation 9 asserts is_exit in the 64-bit class. Neither is taken.
- R11: Operations 14 and 15 in either class, and operations 0 and 9 in the 32-bit class, assert illegal. An illegal instruction is not taken and asserts neither is_call nor is_exit.
- R12: An instruction whose class is neither 5 nor 6 is not taken, asserts no flag, and gives next_pc = pc + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Instruction opcode byte |
| offset | input | 16 | Signed branch displacement in slots |
| imm | input | 32 | Immediate operand |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| pc_in | input | PCW (32) | Program counter of the instruction, in slots |
| out_valid | output | 1 | Registered results are valid |
| next_pc | output | PCW (32) | Program counter that follows |
| taken | output | 1 | The branch was taken |
| is_call | output | 1 | The instruction is a call |
| is_exit | output | 1 | The instruction is an exit |
| illegal | output | 1 | The encoding is not allowed |

## Verification
A fault in the operand path or in the condition logic shows up in the very next result. It appears as a wrong taken bit and a next_pc that differs by the offset plus nothing else. The corner cases are the values that separate signed from unsigned order and the 32-bit view from the 64-bit view. Examples are operands whose bit 31 or bit 63 differ, and upper halves that differ while the lower halves match. Class-legality faults show as a misplaced illegal, is_call or is_exit flag on the same cycle's result. The bench compares every output against a behavioural model after each clock, so any divergence is reported one edge after the instruction.

// File: rtl/br_pkg.sv
// Package: shared encodings for the branch evaluation unit.
// Assumes opcode layout {operation[3:0], operand_select, class[2:0]}.
package br_pkg;
    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    typedef enum logic [3:0] {
        JOP_ALWAYS = 4'h0,
        JOP_EQ     = 4'h1,
        JOP_UGT    = 4'h2,
        JOP_UGE    = 4'h3,
        JOP_TEST   = 4'h4,
        JOP_NE     = 4'h5,
        JOP_SGT    = 4'h6,
        JOP_SGE    = 4'h7,
        JOP_CALL   = 4'h8,
        JOP_EXIT   = 4'h9,
        JOP_ULT    = 4'ha,
        JOP_ULE    = 4'hb,
        JOP_SLT    = 4'hc,
        JOP_SLE    = 4'hd,
        JOP_RSV_E  = 4'he,
        JOP_RSV_F  = 4'hf
    } jop_e;
endpackage

// File: rtl/br_decode.sv
// Module: br_decode
// Splits the opcode byte into class, operand select and operation, and
// classifies the operation. Assumes the caller qualifies with a valid.
module br_decode
    import br_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       jump_cls,
    output logic       narrow,
    output logic       use_src,
    output jop_e       op,
    output logic       kind_always,
    output logic       kind_cond,
    output logic       kind_call,
    output logic       kind_exit,
    output logic       kind_bad
);
    logic [2:0] cls;

    // Field extraction from the opcode byte.
    always_comb begin
        cls      = opcode[2:0];
        use_src  = opcode[3];
        op       = jop_e'(opcode[7:4]);
        jump_cls = (cls == CLS_WIDE) || (cls == CLS_NARROW);
        narrow   = (cls == CLS_NARROW);
    end

    // Operation classification including class legality.
    always_comb begin
        kind_always = 1'b0;
        kind_cond   = 1'b0;
        kind_call   = 1'b0;
        kind_exit   = 1'b0;
        kind_bad    = 1'b0;
        if (jump_cls) begin
            unique case (op)
                JOP_ALWAYS: begin
                    kind_always = !narrow;
                    kind_bad    = narrow;
                end
                JOP_EXIT: begin
                    kind_exit = !narrow;
                    kind_bad  = narrow;
                end
                JOP_CALL:               kind_call = 1'b1;
                JOP_RSV_E, JOP_RSV_F:   kind_bad  = 1'b1;
                default:                kind_cond = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/br_operand_sel.sv
// Module: br_operand_sel
// Selects the right-hand operand (register or sign-extended immediate)
// and forms unsigned and signed views of both operands for the active
// compare width. Assumes DW is even and IMMW <= DW/2.
module br_operand_sel #(
    parameter int DW   = 64,
    parameter int IMMW = 32
) (
    input  logic [DW-1:0]   dst_val,
    input  logic [DW-1:0]   src_val,
    input  logic [IMMW-1:0] imm,
    input  logic            use_src,
    input  logic            narrow,
    output logic [DW-1:0]   lhs_u,
    output logic [DW-1:0]   rhs_u,
    output logic [DW-1:0]   lhs_s,
    output logic [DW-1:0]   rhs_s
);
    localparam int HW = DW / 2;

    logic [DW-1:0] rhs_full;

    // Operand choice: register or immediate sign-extended to DW.
    always_comb begin
        rhs_full = use_src ? src_val : {{(DW-IMMW){imm[IMMW-1]}}, imm};
    end

    // Width views: zero-extended halves for unsigned, sign-extended for signed.
    always_comb begin
        if (narrow) begin
            lhs_u = {{HW{1'b0}}, dst_val[HW-1:0]};
            rhs_u = {{HW{1'b0}}, rhs_full[HW-1:0]};
            lhs_s = {{HW{dst_val[HW-1]}}, dst_val[HW-1:0]};
            rhs_s = {{HW{rhs_full[HW-1]}}, rhs_full[HW-1:0]};
        end else begin
            lhs_u = dst_val;
            rhs_u = rhs_full;
            lhs_s = dst_val;
            rhs_s = rhs_full;
        end
    end
endmodule

// File: rtl/br_cond_eval.sv
// Module: br_cond_eval
// Evaluates the condition of a compare operation on prepared operands.
// Assumes operands were already narrowed/extended by br_operand_sel.
module br_cond_eval
    import br_pkg::*;
#(
    parameter int DW = 64
) (
    input  jop_e          op,
    input  logic [DW-1:0] lhs_u,
    input  logic [DW-1:0] rhs_u,
    input  logic [DW-1:0] lhs_s,
    input  logic [DW-1:0] rhs_s,
    output logic          cond
);
    logic u_eq, u_gt, s_gt;

    // Shared relational primitives.
    always_comb begin
        u_eq = (lhs_u == rhs_u);
        u_gt = (lhs_u > rhs_u);
        s_gt = ($signed(lhs_s) > $signed(rhs_s));
    end

    // Operation table mapping codes onto the primitives.
    always_comb begin
        unique case (op)
            JOP_EQ:   cond = u_eq;
            JOP_NE:   cond = !u_eq;
            JOP_TEST: cond = |(lhs_u & rhs_u);
            JOP_UGT:  cond = u_gt;
            JOP_UGE:  cond = u_gt || u_eq;
            JOP_ULT:  cond = !(u_gt || u_eq);
            JOP_ULE:  cond = !u_gt;
            JOP_SGT:  cond = s_gt;
            JOP_SGE:  cond = s_gt || u_eq;
            JOP_SLT:  cond = !(s_gt || u_eq);
            JOP_SLE:  cond = !s_gt;
            default:  cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_pc_step.sv
// Module: br_pc_step
// Computes the following slot address: pc+1, plus the sign-extended
// offset when the branch is taken. Assumes OFFW <= PCW; wraps modulo 2^PCW.
module br_pc_step #(
    parameter int PCW  = 32,
    parameter int OFFW = 16
) (
    input  logic [PCW-1:0]  pc,
    input  logic [OFFW-1:0] offset,
    input  logic            take,
    output logic [PCW-1:0]  npc
);
    logic [PCW-1:0] disp;

    // Displacement: sign-extended offset or zero.
    always_comb begin
        disp = take ? {{(PCW-OFFW){offset[OFFW-1]}}, offset} : '0;
        npc  = pc + PCW'(1) + disp;
    end
endmodule

// File: rtl/br_eval_unit.sv
// Module: br_eval_unit (top)
// Resolves jump-class instructions: taken decision, next PC and call,
// exit and illegal flags, registered one cycle after in_valid.
// Assumes synchronous active-low reset and a PC counted in slots.
module br_eval_unit
    import br_pkg::*;
#(
    parameter int DW   = 64,
    parameter int PCW  = 32,
    parameter int OFFW = 16,
    parameter int IMMW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      opcode,
    input  logic [OFFW-1:0] offset,
    input  logic [IMMW-1:0] imm,
    input  logic [DW-1:0]   dst_val,
    input  logic [DW-1:0]   src_val,
    input  logic [PCW-1:0]  pc_in,
    output logic            out_valid,
    output logic [PCW-1:0]  next_pc,
    output logic            taken,
    output logic            is_call,
    output logic            is_exit,
    output logic            illegal
);
    logic           jump_cls, narrow, use_src;
    jop_e           op;
    logic           k_always, k_cond, k_call, k_exit, k_bad;
    logic [DW-1:0]  lhs_u, rhs_u, lhs_s, rhs_s;
    logic           cond;
    logic           take_c;
    logic [PCW-1:0] npc_c;

    br_decode u_dec (
        .opcode      (opcode),
        .jump_cls    (jump_cls),
        .narrow      (narrow),
        .use_src     (use_src),
        .op          (op),
        .kind_always (k_always),
        .kind_cond   (k_cond),
        .kind_call   (k_call),
        .kind_exit   (k_exit),
        .kind_bad    (k_bad)
    );

    br_operand_sel #(.DW(DW), .IMMW(IMMW)) u_opnd (
        .dst_val (dst_val),
        .src_val (src_val),
        .imm     (imm),
        .use_src (use_src),
        .narrow  (narrow),
        .lhs_u   (lhs_u),
        .rhs_u   (rhs_u),
        .lhs_s   (lhs_s),
        .rhs_s   (rhs_s)
    );

    br_cond_eval #(.DW(DW)) u_cond (
        .op    (op),
        .lhs_u (lhs_u),
        .rhs_u (rhs_u),
        .lhs_s (lhs_s),
        .rhs_s (rhs_s),
        .cond  (cond)
    );

    // Taken decision combining decode and condition.
    always_comb begin
        take_c = k_always || (k_cond && cond);
    end

    br_pc_step #(.PCW(PCW), .OFFW(OFFW)) u_pc (
        .pc     (pc_in),
        .offset (offset),
        .take   (take_c),
        .npc    (npc_c)
    );

    // Result register; idle cycles clear every output.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
            taken     <= 1'b0;
            is_call   <= 1'b0;
            is_exit   <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            next_pc   <= npc_c;
            taken     <= take_c;
            is_call   <= k_call;
            is_exit   <= k_exit;
            illegal   <= k_bad;
        end
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R11
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken, is_call, is_exit, illegal}));

    // R8
    fallthrough_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> next_pc == $past(pc_in) + PCW'(1));

    // R10
    exit_wide_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_exit |-> $past(opcode[2:0]) == CLS_WIDE);

    // R12
    nonjump_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode[2:1]) != 2'b10 && $past(opcode[2:0]) != CLS_NARROW)
        |-> !(taken || is_call || is_exit || illegal));
endmodule

// File: tb/tb_br_eval_unit.sv
module tb_br_eval_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] pc_in = '0;
    logic        out_valid, taken, is_call, is_exit, illegal;
    logic [31:0] next_pc;

    int n_checks = 0;
    int n_errors = 0;

    logic        e_v, e_t, e_c, e_x, e_i;
    logic [31:0] e_pc;
    string       e_tag;
    bit          have_exp = 0;

    always #4 clk = ~clk;

    br_eval_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .offset(offset), .imm(imm), .dst_val(dst_val), .src_val(src_val),
        .pc_in(pc_in), .out_valid(out_valid), .next_pc(next_pc),
        .taken(taken), .is_call(is_call), .is_exit(is_exit), .illegal(illegal)
    );

    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Behavioural model of one instruction.
    task automatic model(input logic [7:0] oc, input logic [15:0] of, input logic [31:0] im,
                         input logic [63:0] dv, input logic [63:0] sv, input logic [31:0] p,
                         input logic v);
        logic [63:0] b64, ua, ub;
        longint sa, sb;
        bit w32;
        int opn;
        e_v = v; e_t = 0; e_c = 0; e_x = 0; e_i = 0; e_pc = 0;
        if (!v) return;
        e_pc = p + 1;
        if (oc[2:0] != 3'd5 && oc[2:0] != 3'd6) return;
        w32 = (oc[2:0] == 3'd6);
        opn = oc[7:4];
        b64 = oc[3] ? sv : {{32{im[31]}}, im};
        if (w32) begin
            ua = {32'd0, dv[31:0]};
            ub = {32'd0, b64[31:0]};
            sa = longint'($signed(dv[31:0]));
            sb = longint'($signed(b64[31:0]));
        end else begin
            ua = dv; ub = b64;
            sa = $signed(dv); sb = $signed(b64);
        end
        case (opn)
            0:  if (w32) e_i = 1; else e_t = 1;
            1:  e_t = (ua == ub);
            2:  e_t = (ua > ub);
            3:  e_t = (ua >= ub);
            4:  e_t = ((ua & ub) != 0);
            5:  e_t = (ua != ub);
            6:  e_t = (sa > sb);
            7:  e_t = (sa >= sb);
            8:  e_c = 1;
            9:  if (w32) e_i = 1; else e_x = 1;
            10: e_t = (ua < ub);
            11: e_t = (ua <= ub);
            12: e_t = (sa < sb);
            13: e_t = (sa <= sb);
            default: e_i = 1;
        endcase
        if (e_t) e_pc = p + 1 + {{16{of[15]}}, of};
    endtask

    task automatic compare_out();
        n_checks++;
        if (out_valid !== e_v || next_pc !== e_pc || taken !== e_t ||
            is_call !== e_c || is_exit !== e_x || illegal !== e_i) begin
            n_errors++;
            $display("FAIL %s: actual v=%b pc=%0h t=%b c=%b x=%b i=%b expected v=%b pc=%0h t=%b c=%b x=%b i=%b",
                     e_tag, out_valid, next_pc, taken, is_call, is_exit, illegal,
                     e_v, e_pc, e_t, e_c, e_x, e_i);
        end
    endtask

    // Drive one cycle; checks the previous cycle's expectation first.
    task automatic step(input string tag, input logic v, input logic [7:0] oc,
                        input logic [15:0] of, input logic [31:0] im,
                        input logic [63:0] dv, input logic [63:0] sv, input logic [31:0] p);
        @(negedge clk);
        if (have_exp) compare_out();
        in_valid = v; opcode = oc; offset = of; imm = im;
        dst_val = dv; src_val = sv; pc_in = p;
        model(oc, of, im, dv, sv, p, v);
        e_tag = tag;
        have_exp = 1;
    endtask

    function automatic logic [7:0] mk(input int opn, input bit src, input bit w32);
        return {opn[3:0], src, w32 ? 3'd6 : 3'd5};
    endfunction

    initial begin
        // R1: outputs during and right after reset
        repeat (3) @(negedge clk);
        n_checks++;
        if ({out_valid, taken, is_call, is_exit, illegal} !== 5'b0 || next_pc !== 32'd0) begin
            n_errors++;
            $display("FAIL R1: actual v=%b pc=%0h expected all zero", out_valid, next_pc);
        end
        rst_n = 1'b1;
        // R1 / R2: idle cycle
        step("R2", 0, mk(1, 1, 0), 16'd5, 0, 1, 1, 32'h100);
        // R4: equality, inequality, bit test
        step("R4", 1, mk(1, 1, 0), 16'd10, 0, 64'd7, 64'd7, 32'h100);
        step("R4", 1, mk(1, 1, 0), 16'd10, 0, 64'd7, 64'd8, 32'h100);
        step("R4", 1, mk(5, 1, 0), 16'hfff0, 0, 64'd7, 64'd8, 32'h100);
        step("R4", 1, mk(4, 1, 0), 16'd3, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 32'h20);
        step("R4", 1, mk(4, 1, 1), 16'd3, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 32'h20);
        // R5: unsigned order with top bit set
        step("R5", 1, mk(2, 1, 0), 16'd4, 0, 64'hffff_ffff_ffff_ffff, 64'd1, 32'h40);
        step("R5", 1, mk(10, 1, 0), 16'd4, 0, 64'hffff_ffff_ffff_ffff, 64'd1, 32'h40);
        step("R5", 1, mk(3, 1, 0), 16'd4, 0, 64'd9, 64'd9, 32'h40);
        step("R5", 1, mk(11, 1, 1), 16'd4, 0, 64'd9, 64'd10, 32'h40);
        // R6: signed order, sign bit 63 vs 31
        step("R6", 1, mk(6, 1, 0), 16'd2, 0, 64'hffff_ffff_ffff_ffff, 64'd1, 32'h60);
        step("R6", 1, mk(12, 1, 0), 16'd2, 0, 64'hffff_ffff_ffff_ffff, 64'd1, 32'h60);
        step("R6", 1, mk(12, 1, 1), 16'd2, 0, 64'h0000_0000_8000_0000, 64'd1, 32'h60);
        step("R6", 1, mk(12, 1, 0), 16'd2, 0, 64'h0000_0000_8000_0000, 64'd1, 32'h60);
        step("R6", 1, mk(7, 1, 0), 16'd2, 0, 64'd5, 64'd5, 32'h60);
        step("R6", 1, mk(13, 1, 1), 16'd2, 0, 64'd6, 64'd5, 32'h60);
        // R7: immediate sign extension and narrow masking
        step("R7", 1, mk(1, 0, 0), 16'd8, 32'hffff_ffff, 64'hffff_ffff_ffff_ffff, 0, 32'h80);
        step("R7", 1, mk(1, 0, 0), 16'd8, 32'hffff_ffff, 64'h0000_0000_ffff_ffff, 0, 32'h80);
        step("R7", 1, mk(1, 0, 1), 16'd8, 32'hffff_ffff, 64'h0000_0000_ffff_ffff, 0, 32'h80);
        step("R7", 1, mk(1, 1, 1), 16'd8, 0, 64'h1234_0000_0000_0042, 64'h9999_0000_0000_0042, 32'h80);
        // R8: backward branch and wrap
        step("R8", 1, mk(0, 0, 0), 16'h8000, 0, 0, 0, 32'h10);
        step("R8", 1, mk(0, 0, 0), 16'h7fff, 0, 0, 0, 32'hffff_fff0);
        // R9: always-jump in wide class
        step("R9", 1, mk(0, 1, 0), 16'd20, 0, 0, 0, 32'h200);
        // R10: call both classes, exit wide
        step("R10", 1, mk(8, 0, 0), 16'd20, 0, 0, 0, 32'h300);
        step("R10", 1, mk(8, 0, 1), 16'd20, 0, 0, 0, 32'h300);
        step("R10", 1, mk(9, 0, 0), 16'd20, 0, 0, 0, 32'h300);
        // R11: illegal encodings
        step("R11", 1, mk(0, 0, 1), 16'd20, 0, 0, 0, 32'h400);
        step("R11", 1, mk(9, 0, 1), 16'd20, 0, 0, 0, 32'h400);
        step("R11", 1, mk(14, 1, 0), 16'd20, 0, 0, 0, 32'h400);
        step("R11", 1, mk(15, 1, 1), 16'd20, 0, 0, 0, 32'h400);
        // R12: non-jump classes
        step("R12", 1, 8'h07, 16'd20, 0, 0, 0, 32'h500);
        step("R12", 1, 8'h04, 16'd20, 0, 0, 0, 32'h500);
        // R3: mixed random encodings across fields
        for (int k = 0; k < 400; k++) begin
            logic [7:0] oc;
            oc = 8'($urandom);
            if (k % 4 != 0) oc[2:0] = (k % 2) ? 3'd5 : 3'd6;
            step("R3", (k % 9) != 0, oc, 16'($urandom), $urandom,
                 {$urandom, $urandom}, (k % 3 == 0) ? {$urandom, $urandom} : 64'($urandom % 4),
                 $urandom);
        end
        // R2: drain the last instruction
        step("R2", 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_out();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule